// File: doc/BRIEF.md
# Debug Array Access Staging Controller

This block lets debug software reach a core's level-1 arrays through a coprocessor-style register port. The request carries a primary register number, a secondary register number and a two-level opcode selector, plus a direction flag, a 32-bit data word and the core's security and privilege state. Each side, instruction and data, owns a pair of 32-bit staging words: a low word and a high word. Software fills them, then issues an array write command. Or it issues an array read command and collects the captured entry from the pair.

Every array keeps only as many bits as it is wide, and the bits above that width are masked on both directions. The arrays are modelled as small register files of 16 entries. The entry index comes from the low four bits of the command's data word. An array read finishes one cycle after its command. During that cycle the block is busy and drops any request that arrives. Requests made outside the secure privileged state, and encodings that are not recognised, raise a one-cycle error and change nothing.

Top module: `dbg_array_stager`

## Requirements
- R1: With primary number 15, secondary 0 (data side) or 1 (instruction side), and selector 0 (low word) or 1 (high word), a write request stores all 32 data bits in that staging word. A read request returns the word on `rd_data` with `rd_valid` high in the cycle after the request.
- R2: A write request with primary number 15 and secondary 0 (data side) or 1 (instruction side) is an array write when the selector is 2 to 7. The selectors map to: 2 tag-CAM, 3 attribute, 4 physical address, 5 hit-vector, 6 cache tag, 7 cache data. The write copies {high word, low word} of that side into entry `req_wdata[3:0]`.
- R3: A write request with secondary 2 (data side) or 3 (instruction side) and selector 2 to 7 is an array read of the same arrays. It loads the staging pair at the clock edge that follows the command. `busy` is high for exactly that one cycle, and a request arriving during it has no effect: no error, no read response, no state change.
- R4: The array widths are: tag-CAM 37, attribute 12, physical address 29, hit-vector 8, cache tag 23, cache data 38, branch target 60, branch history 32. An array read returns zero in every staging bit above the array's width, and an array write discards those bits.
- R5: For an array 32 bits wide or narrower, an array read leaves the high staging word unchanged, and an array write ignores the high word.
- R6: The branch target and branch history arrays exist only on the instruction side. Secondary 5 writes them and secondary 7 reads them, with selector 3 for the branch target array and selector 2 for the branch history array.
- R7: Any request made while `sec_state` or `priv_state` is low sets `undef_err` for one cycle. It changes no staging word and no array entry. If it was a read request, `rd_valid` is high and `rd_data` is zero.
- R8: Any other encoding raises `undef_err` for one cycle and changes nothing. This covers a primary number other than 15, a secondary number outside {0,1,2,3,5,7}, a read-direction request to an array-command encoding, and selectors 0, 1 or 4–7 with secondary 5 or 7.
- R9: After reset, every staging word and every array entry is zero, and `rd_valid`, `undef_err` and `busy` are low.
- R10: The data side and the instruction side are independent. No command on one side changes the other side's staging words or arrays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_wr | input | 1 | 1: move to coprocessor (write or command), 0: move from coprocessor (read) |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_opc2 | input | 3 | Selector |
| req_wdata | input | 32 | Write data, or entry index in bits [3:0] for array commands |
| sec_state | input | 1 | Core is in secure state |
| priv_state | input | 1 | Core is in a privileged mode |
| rd_valid | output | 1 | Read response valid (cycle after request) |
| rd_data | output | 32 | Read response data |
| undef_err | output | 1 | One-cycle undefined-access error |
| busy | output | 1 | Array read capture in progress |

## Verification
Two functions share one cycle: the capture of an array read into a side's staging pair, and a newly arriving request on that pair. The bench provokes this by issuing an array read and then, in the very next cycle, a staging write to the same side. It also lets random traffic place arbitrary requests in busy cycles. The collision is judged correct when the later staging read shows the captured entry and the dropped request produced neither an error nor a read response.

// File: rtl/dbgarr_pkg.sv
// Package: shared encodings, decoded-command type and array geometry.
// Assumes at most 64 bits per array entry (two 32-bit staging words).
package dbgarr_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned PAIR_W  = 2 * WORD_W;
    localparam int unsigned N_SIDES = 2;
    localparam int unsigned N_ARRS  = 8;
    localparam int unsigned N_SIDE_ARRS_D = 6;   // data side lacks branch arrays

    localparam logic SIDE_D = 1'b0;
    localparam logic SIDE_I = 1'b1;

    typedef enum logic [2:0] {
        ARR_CAM  = 3'd0,
        ARR_ATTR = 3'd1,
        ARR_PA   = 3'd2,
        ARR_HVEC = 3'd3,
        ARR_TAG  = 3'd4,
        ARR_DATA = 3'd5,
        ARR_BTB  = 3'd6,
        ARR_GHB  = 3'd7
    } arr_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_STG_RD = 3'd1,
        OP_STG_WR = 3'd2,
        OP_ARR_RD = 3'd3,
        OP_ARR_WR = 3'd4,
        OP_BAD    = 3'd5
    } op_e;

    typedef struct packed {
        op_e  op;
        logic side;
        logic hi;
        arr_e arr;
    } cmd_t;

    // Width in bits of each modelled array.
    function automatic int unsigned arr_width(input int unsigned id);
        case (id)
            0:       return 37;
            1:       return 12;
            2:       return 29;
            3:       return 8;
            4:       return 23;
            5:       return 38;
            6:       return 60;
            default: return 32;
        endcase
    endfunction

    // True when the array spills into the high staging word.
    function automatic logic arr_is_wide(input arr_e id);
        return arr_width(int'(id)) > WORD_W;
    endfunction

endpackage

// File: rtl/dbgarr_decode.sv
// Module: dbgarr_decode
// Turns one register-port request into a decoded command. Purely
// combinational. Assumes the caller gates the result while busy.
module dbgarr_decode
    import dbgarr_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_wr,
    input  logic [3:0] req_crn,
    input  logic [3:0] req_crm,
    input  logic [2:0] req_opc2,
    input  logic       sec_state,
    input  logic       priv_state,
    output cmd_t       cmd
);

    // Classify the request by primary, secondary and selector fields.
    always_comb begin
        cmd      = '0;
        cmd.op   = OP_NONE;
        cmd.arr  = ARR_CAM;
        if (req_valid) begin
            if (!(sec_state && priv_state) || req_crn != 4'd15) begin
                cmd.op = OP_BAD;
            end else begin
                case (req_crm)
                    4'd0, 4'd1: begin
                        cmd.side = req_crm[0];
                        if (req_opc2 <= 3'd1) begin
                            cmd.op = req_wr ? OP_STG_WR : OP_STG_RD;
                            cmd.hi = req_opc2[0];
                        end else if (req_wr) begin
                            cmd.op  = OP_ARR_WR;
                            cmd.arr = arr_e'(req_opc2 - 3'd2);
                        end else begin
                            cmd.op = OP_BAD;
                        end
                    end
                    4'd2, 4'd3: begin
                        cmd.side = req_crm[0];
                        if (req_wr && req_opc2 >= 3'd2) begin
                            cmd.op  = OP_ARR_RD;
                            cmd.arr = arr_e'(req_opc2 - 3'd2);
                        end else begin
                            cmd.op = OP_BAD;
                        end
                    end
                    4'd5, 4'd7: begin
                        cmd.side = SIDE_I;
                        if (req_wr && (req_opc2 == 3'd2 || req_opc2 == 3'd3)) begin
                            cmd.op  = req_crm[1] ? OP_ARR_RD : OP_ARR_WR;
                            cmd.arr = req_opc2[0] ? ARR_BTB : ARR_GHB;
                        end else begin
                            cmd.op = OP_BAD;
                        end
                    end
                    default: cmd.op = OP_BAD;
                endcase
            end
        end
    end

endmodule

// File: rtl/dbgarr_bank.sv
// Module: dbgarr_bank
// One modelled array: DEPTH entries of WIDTH bits, one synchronous write
// port and one combinational read port. Clears to zero on reset.
module dbgarr_bank #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store one entry per write strobe; clear all entries on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Present the addressed entry.
    always_comb rdata = mem[ridx];

endmodule

// File: rtl/dbgarr_stage.sv
// Module: dbgarr_stage
// Low/high staging word pair of one side. Software writes load a whole
// word; an array capture loads the low word and, for wide arrays, the
// high word. Assumes the two sources never fire in the same cycle;
// capture takes precedence if they do.
module dbgarr_stage
    import dbgarr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic              sw_hi,
    input  logic [WORD_W-1:0] sw_wdata,
    input  logic              cap_en,
    input  logic              cap_wide,
    input  logic [PAIR_W-1:0] cap_data,
    output logic [WORD_W-1:0] lo_q,
    output logic [WORD_W-1:0] hi_q
);

    // Update the low word from a capture or a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                lo_q <= '0;
        else if (cap_en)           lo_q <= cap_data[WORD_W-1:0];
        else if (sw_we && !sw_hi)  lo_q <= sw_wdata;
    end

    // Update the high word from a wide capture or a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                   hi_q <= '0;
        else if (cap_en && cap_wide)  hi_q <= cap_data[PAIR_W-1:WORD_W];
        else if (!cap_en && sw_we && sw_hi) hi_q <= sw_wdata;
    end

endmodule

// File: rtl/dbg_array_stager.sv
// Module: dbg_array_stager
// Debug access controller: decodes register-port requests, keeps the
// staging pairs of both sides, and moves masked entries between them and
// the modelled arrays. Array reads complete one cycle after the command;
// requests arriving in that cycle are dropped. Responses are registered.
module dbg_array_stager
    import dbgarr_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_wr,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_opc2,
    input  logic [31:0] req_wdata,
    input  logic        sec_state,
    input  logic        priv_state,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        undef_err,
    output logic        busy
);

    cmd_t                   cmd_raw;
    cmd_t                   cmd;
    logic                   pend_side;
    arr_e                   pend_arr;
    logic [IDX_W-1:0]       pend_idx;
    logic [IDX_W-1:0]       cmd_idx;
    logic [N_SIDES-1:0][WORD_W-1:0] stg_lo;
    logic [N_SIDES-1:0][WORD_W-1:0] stg_hi;
    logic [PAIR_W-1:0]      rd_bus [N_SIDES][N_ARRS];
    logic [PAIR_W-1:0]      cap_data;

    assign cmd_idx = req_wdata[IDX_W-1:0];

    dbgarr_decode u_decode (
        .req_valid  (req_valid),
        .req_wr     (req_wr),
        .req_crn    (req_crn),
        .req_crm    (req_crm),
        .req_opc2   (req_opc2),
        .sec_state  (sec_state),
        .priv_state (priv_state),
        .cmd        (cmd_raw)
    );

    // Drop every request that arrives while a capture is pending.
    always_comb begin
        cmd = cmd_raw;
        if (busy) cmd.op = OP_NONE;
    end

    // Track the one outstanding array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            pend_side <= SIDE_D;
            pend_arr  <= ARR_CAM;
            pend_idx  <= '0;
        end else begin
            busy <= (cmd.op == OP_ARR_RD);
            if (cmd.op == OP_ARR_RD) begin
                pend_side <= cmd.side;
                pend_arr  <= cmd.arr;
                pend_idx  <= cmd_idx;
            end
        end
    end

    // Select the captured entry from the pending side and array.
    always_comb cap_data = rd_bus[pend_side][pend_arr];

    // Build each side's staging pair and its array set.
    for (genvar s = 0; s < int'(N_SIDES); s++) begin : g_side
        logic [PAIR_W-1:0] pair;
        assign pair = {stg_hi[s], stg_lo[s]};

        dbgarr_stage u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .sw_we    (cmd.op == OP_STG_WR && cmd.side == 1'(s)),
            .sw_hi    (cmd.hi),
            .sw_wdata (req_wdata),
            .cap_en   (busy && pend_side == 1'(s)),
            .cap_wide (arr_is_wide(pend_arr)),
            .cap_data (cap_data),
            .lo_q     (stg_lo[s]),
            .hi_q     (stg_hi[s])
        );

        for (genvar a = 0; a < int'(N_ARRS); a++) begin : g_arr
            if (s == 1 || a < int'(N_SIDE_ARRS_D)) begin : g_bank
                localparam int unsigned W = arr_width(a);
                logic [W-1:0] rdat;

                dbgarr_bank #(.WIDTH(W), .DEPTH(DEPTH)) u_bank (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .we    (cmd.op == OP_ARR_WR && cmd.side == 1'(s) && cmd.arr == arr_e'(a)),
                    .widx  (cmd_idx),
                    .wdata (pair[W-1:0]),
                    .ridx  (pend_idx),
                    .rdata (rdat)
                );
                assign rd_bus[s][a] = {{(PAIR_W-W){1'b0}}, rdat};
            end else begin : g_absent
                assign rd_bus[s][a] = '0;
            end
        end
    end

    // Register the response for staging reads and the error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            undef_err <= 1'b0;
        end else begin
            undef_err <= (cmd.op == OP_BAD);
            rd_valid  <= (cmd.op == OP_STG_RD) || (cmd.op == OP_BAD && !req_wr);
            if (cmd.op == OP_STG_RD)
                rd_data <= cmd.hi ? stg_hi[cmd.side] : stg_lo[cmd.side];
            else
                rd_data <= '0;
        end
    end

endmodule

// File: rtl/dbgarr_checks.sv
// Module: dbgarr_checks
// Property checker bound to dbg_array_stager. Observes ports and the
// staging words; drives nothing.
module dbgarr_checks (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_wr,
    input logic              sec_state,
    input logic              priv_state,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              undef_err,
    input logic              busy,
    input logic [1:0][31:0]  stg_lo,
    input logic [1:0][31:0]  stg_hi
);

    // R3: the capture window lasts a single cycle.
    a_r3_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R3: the cycle that opens a capture carries no other response.
    a_r3_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!undef_err && !rd_valid));

    // R7: a gated request that is not dropped raises the error.
    a_r7_gate_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !(sec_state && priv_state)) |=> undef_err);

    // R7: a gated read returns zero.
    a_r7_gate_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_wr && !(sec_state && priv_state)) |=> (rd_valid && rd_data == 32'd0));

    // R8: an error is only ever the answer to a request.
    a_r8_err_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        undef_err |-> $past(req_valid));

    // R7: a refused request leaves every staging word unchanged.
    a_r7_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        undef_err |-> ($stable(stg_lo) && $stable(stg_hi)));

    // R1: read data is never presented without a response strobe.
    a_r1_data_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != 32'd0) |-> rd_valid);

endmodule

bind dbg_array_stager dbgarr_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_wr     (req_wr),
    .sec_state  (sec_state),
    .priv_state (priv_state),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .undef_err  (undef_err),
    .busy       (busy),
    .stg_lo     (stg_lo),
    .stg_hi     (stg_hi)
);

// File: tb/dbg_array_stager_bench.sv
`timescale 1ns/1ps
module dbg_array_stager_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_wr = 1'b0;
    logic [3:0]  req_crn = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_opc2 = '0;
    logic [31:0] req_wdata = '0;
    logic        sec_state = 1'b1;
    logic        priv_state = 1'b1;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        undef_err;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the staging words and arrays.
    logic [31:0] m_stg [2][2];
    logic [63:0] m_arr [2][8][16];
    bit          m_pend = 1'b0;
    logic [31:0] last_rd;

    always #2 clk = ~clk;

    dbg_array_stager u_dbg_array_stager (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
        .req_crn(req_crn), .req_crm(req_crm), .req_opc2(req_opc2),
        .req_wdata(req_wdata), .sec_state(sec_state), .priv_state(priv_state),
        .rd_valid(rd_valid), .rd_data(rd_data), .undef_err(undef_err), .busy(busy)
    );

    function automatic int m_width(input int a);
        case (a)
            0: return 37; 1: return 12; 2: return 29; 3: return 8;
            4: return 23; 5: return 38; 6: return 60; default: return 32;
        endcase
    endfunction

    // Request classes: 1 staging rd, 2 staging wr, 3 array rd, 4 array wr,
    // 5 gated, 6 unknown encoding.
    function automatic int classify(input logic wr, input logic [3:0] crn,
            input logic [3:0] crm, input logic [2:0] op2, input logic sec,
            input logic prv, output int s, output int h, output int a);
        s = 0; h = 0; a = 0;
        if (!(sec && prv)) return 5;
        if (crn != 4'd15) return 6;
        if (crm == 4'd0 || crm == 4'd1) begin
            s = int'(crm == 4'd1);
            if (op2 == 3'd0 || op2 == 3'd1) begin h = int'(op2); return wr ? 2 : 1; end
            a = int'(op2) - 2;
            return wr ? 4 : 6;
        end
        if (crm == 4'd2 || crm == 4'd3) begin
            s = int'(crm == 4'd3);
            if (wr && op2 >= 3'd2) begin a = int'(op2) - 2; return 3; end
            return 6;
        end
        if (crm == 4'd5 || crm == 4'd7) begin
            s = 1;
            if (wr && op2 == 3'd3) begin a = 6; return (crm == 4'd5) ? 4 : 3; end
            if (wr && op2 == 3'd2) begin a = 7; return (crm == 4'd5) ? 4 : 3; end
            return 6;
        end
        return 6;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Drive one request, advance the model, compare the registered response.
    task automatic do_req(input logic wr, input logic [3:0] crn, input logic [3:0] crm,
            input logic [2:0] op2, input logic [31:0] d, input logic sec, input logic prv);
        int s, h, a, c;
        logic [63:0] v;
        logic e_err, e_val, e_busy;
        logic [31:0] e_dat;
        string tag;
        c = classify(wr, crn, crm, op2, sec, prv, s, h, a);
        e_err = 0; e_val = 0; e_busy = 0; e_dat = '0;
        if (m_pend) begin
            tag = "R3";
            m_pend = 0;
        end else begin
            case (c)
                1: begin tag = "R1"; e_val = 1; e_dat = m_stg[s][h]; end
                2: begin tag = "R1"; m_stg[s][h] = d; end
                3: begin
                    tag = (a >= 6) ? "R6" : "R3";
                    v = m_arr[s][a][d[3:0]];
                    m_stg[s][0] = v[31:0];
                    if (m_width(a) > 32) m_stg[s][1] = v[63:32];
                    e_busy = 1; m_pend = 1;
                end
                4: begin
                    tag = (a >= 6) ? "R6" : "R2";
                    v = {m_stg[s][1], m_stg[s][0]};
                    m_arr[s][a][d[3:0]] = v & ((64'd1 << m_width(a)) - 64'd1);
                end
                5: begin tag = "R7"; e_err = 1; e_val = !wr; end
                default: begin tag = "R8"; e_err = 1; e_val = !wr; end
            endcase
        end
        req_valid = 1; req_wr = wr; req_crn = crn; req_crm = crm;
        req_opc2 = op2; req_wdata = d; sec_state = sec; priv_state = prv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        last_rd = rd_data;
        chk(tag, {rd_data, 28'd0, undef_err, rd_valid, busy, 1'b0},
                 {e_dat, 28'd0, e_err, e_val, e_busy, 1'b0});
    endtask

    task automatic idle();
        req_valid = 0;
        @(posedge clk); @(negedge clk);
        m_pend = 0;
    endtask

    // Shorthands for secure privileged accesses.
    task automatic stg_wr(input int s, input int h, input logic [31:0] d);
        do_req(1, 15, 4'(s), 3'(h), d, 1, 1);
    endtask
    task automatic stg_rd(input int s, input int h);
        do_req(0, 15, 4'(s), 3'(h), 0, 1, 1);
    endtask

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_stg[s][0] = '0; m_stg[s][1] = '0;
            for (int a = 0; a < 8; a++)
                for (int i = 0; i < 16; i++) m_arr[s][a][i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", {rd_valid, undef_err, busy}, 3'b000);
        rst_n = 1;
        @(negedge clk);

        // R9: staging and arrays come up zero.
        stg_rd(0, 0); chk("R9", last_rd, 0);
        stg_rd(1, 1); chk("R9", last_rd, 0);
        do_req(1, 15, 3, 7, 32'd5, 1, 1); idle();
        stg_rd(1, 0); chk("R9", last_rd, 0);

        // R4: wide write keeps only 37 bits of the tag-CAM.
        stg_wr(0, 0, 32'hFFFF_FFFF); stg_wr(0, 1, 32'hFFFF_FFFF);
        do_req(1, 15, 0, 2, 32'd3, 1, 1);
        stg_wr(0, 0, 0); stg_wr(0, 1, 0);
        do_req(1, 15, 2, 2, 32'd3, 1, 1); idle();
        stg_rd(0, 0); chk("R4", last_rd, 32'hFFFF_FFFF);
        stg_rd(0, 1); chk("R4", last_rd, 32'h0000_001F);

        // R5: narrow hit-vector read leaves the high word alone.
        stg_wr(1, 0, 32'h1234_56AB); stg_wr(1, 1, 32'hA5A5_A5A5);
        do_req(1, 15, 1, 5, 32'd9, 1, 1);
        stg_wr(1, 0, 32'hFFFF_FFFF);
        do_req(1, 15, 3, 5, 32'd9, 1, 1); idle();
        stg_rd(1, 0); chk("R5", last_rd, 32'h0000_00AB);
        stg_rd(1, 1); chk("R5", last_rd, 32'hA5A5_A5A5);

        // R6: branch target on the instruction side, 60 bits.
        stg_wr(1, 0, 32'hCAFE_F00D); stg_wr(1, 1, 32'hFFFF_FFFF);
        do_req(1, 15, 5, 3, 32'd15, 1, 1);
        stg_wr(1, 1, 0);
        do_req(1, 15, 7, 3, 32'd15, 1, 1); idle();
        stg_rd(1, 1); chk("R6", last_rd, 32'h0FFF_FFFF);

        // R3: staging write in the capture cycle is dropped.
        do_req(1, 15, 3, 7, 32'd15, 1, 1);
        stg_wr(1, 0, 32'h7777_7777);
        stg_rd(1, 0); chk("R3", last_rd, 32'h0000_0000);

        // R10: data-side activity leaves instruction side intact.
        stg_wr(1, 0, 32'h0BAD_BEEF);
        stg_wr(0, 0, 32'h1111_1111); do_req(1, 15, 2, 4, 32'd0, 1, 1); idle();
        stg_rd(1, 0); chk("R10", last_rd, 32'h0BAD_BEEF);

        // R7 / R8: refused requests.
        do_req(1, 15, 1, 0, 32'hDEAD_0000, 0, 1);
        do_req(0, 15, 1, 0, 0, 1, 0);
        stg_rd(1, 0); chk("R7", last_rd, 32'h0BAD_BEEF);
        do_req(1, 14, 0, 0, 32'h1, 1, 1);
        do_req(1, 15, 5, 4, 32'h1, 1, 1);
        do_req(0, 15, 2, 3, 32'h1, 1, 1);
        do_req(1, 15, 4, 0, 32'h1, 1, 1);

        // Random traffic, fixed seed.
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'h5EED_1234);
        end
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] crn, crm;
            logic [2:0] op2;
            logic wr, sec, prv;
            int pick;
            pick = int'($urandom_range(0, 7));
            case (pick)
                0: crm = 4'd0; 1: crm = 4'd1; 2: crm = 4'd2; 3: crm = 4'd3;
                4: crm = 4'd5; 5: crm = 4'd7; 6: crm = 4'($urandom_range(0, 15));
                default: crm = 4'($urandom_range(0, 1));
            endcase
            crn = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(0, 14)) : 4'd15;
            op2 = 3'($urandom_range(0, 7));
            wr  = ($urandom_range(0, 3) != 0);
            sec = ($urandom_range(0, 15) != 0);
            prv = ($urandom_range(0, 15) != 0);
            do_req(wr, crn, crm, op2, $urandom, sec, prv);
            if ($urandom_range(0, 3) == 0) idle();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule